// File: doc/BRIEF.md
# AND-NOT Flag Test Execution Unit

This unit executes a single instruction of a 32-bit processor: the destination operand is ANDed with the bitwise inverse of the source operand. The main use is setting flags without writing anything back. When the instruction asks for it, the zero flag records whether the masked value is all zeros. The carry flag likewise records the odd parity of the masked value. When the write-back effect bit is set, the same instruction becomes a destructive AND-NOT. The unit then raises a write strobe together with the destination register address taken from the instruction. The source operand is either a register value or a 9-bit literal from the instruction. The literal is zero-extended before it is inverted.

An instruction enters on a valid/ready handshake. It is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle, so the upstream stage must hold the instruction, operands and flags steady until it sees ready. While the unit is busy, `in_valid` has no effect. The operation runs through a fixed four-stage sequence: decode, operand select, compute, flag evaluation. It ends with a one-cycle `done` strobe. Results and flags then hold until the next completion. If the opcode does not match, or the condition field is not "always", the unit still takes the same time. It then completes with the incoming flags passed through unchanged and no write strobe.

Top module: `andn_flag_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after it is released, `in_ready` is 1 and `done`, `wr_en`, `z_out`, `c_out`, `result` and `wr_addr` are 0.
- R2: An instruction is accepted on a rising edge with `in_valid` and `in_ready` both 1. `in_ready` is 0 for the next four cycles. `done` is 1 for exactly one cycle, the one following the fourth rising edge after the accepting edge, and `in_ready` is 1 again in that cycle. `in_valid` while busy has no effect on the outcome.
- R3: Instruction layout, MSB first: opcode [31:26] = 011001, Z-effect [25], C-effect [24], R-effect [23], I [22], condition [21:18], destination address [17:9], source field [8:0]. For an executed instruction with I=0, `result` in the done cycle equals `dst_val & ~src_val`.
- R4: With I=1, the source operand is the source field [8:0] zero-extended to 32 bits, so `result` = `dst_val & ~{23'b0, insn[8:0]}`.
- R5: For an executed instruction with Z-effect = 1, `z_out` is 1 exactly when the result is zero. Otherwise `z_out` equals `z_in` as sampled at acceptance.
- R6: For an executed instruction with C-effect = 1, `c_out` is 1 exactly when the result has an odd number of 1 bits. Otherwise `c_out` equals `c_in` as sampled at acceptance.
- R7: `wr_en` is 1 only in the done cycle, and only when the instruction executes with R-effect = 1. `wr_addr` then shows insn[17:9].
- R8: An instruction executes only when the opcode is 011001 and the condition is 1111. Otherwise it completes with the same timing, with `wr_en` = 0, `z_out`/`c_out` equal to the accepted `z_in`/`c_in`, and `result` and `wr_addr` unchanged.
- R9: `result`, `z_out`, `c_out` and `wr_addr` change only on the edge that raises `done`, and they hold between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are offered |
| in_ready | output | 1 | Unit idle and able to accept |
| insn | input | 32 | Instruction word |
| dst_val | input | 32 | Destination register value |
| src_val | input | 32 | Source register value |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| result | output | 32 | AND-NOT value |
| wr_en | output | 1 | Destination write strobe (done cycle only) |
| wr_addr | output | 9 | Destination register address |
| done | output | 1 | One-cycle completion strobe |

## Verification
Suppose the sequencer stalls, skips a stage or loses its state. The fault then shows at the ports on the first instruction: `done` arrives on a cycle other than the fourth edge after acceptance, or `in_ready` stays low. Suppose instead a latched effect bit, a captured flag or the operand register is corrupted. The fault then appears in the single done cycle of that instruction, as a wrong `z_out`/`c_out`, a wrong masked value or a stray `wr_en`. A flaw in the parity or zero logic shows up only for particular bit patterns. That is why the literal path is swept over every 9-bit value and all sixteen effect combinations are applied to several operand patterns.

// File: rtl/andn_flag_pkg.sv
package andn_flag_pkg;
  localparam int XLEN   = 32;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 6;
  localparam int COND_W = 4;
  localparam int ADDR_W = 9;
  localparam int SRC_W  = 9;
  localparam int LAT    = 4;

  localparam logic [OPC_W-1:0]  OPC_ANDN    = 6'b011001;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'b1111;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic              eff_z;
    logic              eff_c;
    logic              eff_w;
    logic              imm;
    logic [COND_W-1:0] cond;
    logic [ADDR_W-1:0] dst_a;
    logic [SRC_W-1:0]  src_f;
  } insn_t;

  typedef struct packed {
    logic              go;
    logic              eff_z;
    logic              eff_c;
    logic              eff_w;
    logic              imm;
    logic [ADDR_W-1:0] dst_a;
    logic [SRC_W-1:0]  lit;
  } ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DECODE  = 3'd1,
    ST_OPERAND = 3'd2,
    ST_COMPUTE = 3'd3,
    ST_FLAGS   = 3'd4
  } state_t;
endpackage

// File: rtl/andn_decode.sv
module andn_decode
  import andn_flag_pkg::*;
(
  input  insn_t word,
  output ctl_t  ctl
);
  logic opc_hit;
  logic cond_hit;

  always_comb begin
    opc_hit   = (word.opc == OPC_ANDN);
    cond_hit  = (word.cond == COND_ALWAYS);
    ctl.go    = opc_hit && cond_hit;
    ctl.eff_z = word.eff_z;
    ctl.eff_c = word.eff_c;
    ctl.eff_w = word.eff_w;
    ctl.imm   = word.imm;
    ctl.dst_a = word.dst_a;
    ctl.lit   = word.src_f;
  end
endmodule

// File: rtl/andn_operand.sv
module andn_operand
  import andn_flag_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic [DATA_W-1:0] reg_val,
  input  logic [SRC_W-1:0]  lit,
  input  logic              imm,
  output logic [DATA_W-1:0] op
);
  logic [DATA_W-1:0] lit_ext;

  always_comb begin
    lit_ext = DATA_W'(lit);
    op      = imm ? lit_ext : reg_val;
  end
endmodule

// File: rtl/andn_flagcalc.sv
module andn_flagcalc #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  output logic         is_zero,
  output logic         is_odd
);
  localparam int LV = (W > 1) ? $clog2(W) : 1;
  localparam int PW = 1 << LV;

  logic [PW-1:0] xr [LV+1];
  logic [PW-1:0] orr [LV+1];

  assign xr[0]  = PW'(val);
  assign orr[0] = PW'(val);

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int NODES = PW >> (l + 1);
    for (genvar i = 0; i < NODES; i++) begin : g_node
      assign xr[l+1][i]  = xr[l][2*i] ^ xr[l][2*i+1];
      assign orr[l+1][i] = orr[l][2*i] | orr[l][2*i+1];
    end
    assign xr[l+1][PW-1:NODES]  = '0;
    assign orr[l+1][PW-1:NODES] = '0;
  end

  assign is_odd  = xr[LV][0];
  assign is_zero = ~orr[LV][0];
endmodule

// File: rtl/andn_flag_unit.sv
module andn_flag_unit
  import andn_flag_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic              z_in,
  input  logic              c_in,
  output logic              z_out,
  output logic              c_out,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done
);
  state_t            st;
  insn_t             insn_q;
  ctl_t              ctl_d;
  ctl_t              ctl_q;
  logic [DATA_W-1:0] dst_q;
  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] op_d;
  logic [DATA_W-1:0] op_q;
  logic [DATA_W-1:0] res_q;
  logic              z_q;
  logic              c_q;
  logic              f_zero;
  logic              f_odd;

  andn_decode u_dec (
    .word (insn_q),
    .ctl  (ctl_d)
  );

  andn_operand #(.DATA_W(DATA_W)) u_opnd (
    .reg_val (src_q),
    .lit     (ctl_q.lit),
    .imm     (ctl_q.imm),
    .op      (op_d)
  );

  andn_flagcalc #(.W(DATA_W)) u_flag (
    .val     (res_q),
    .is_zero (f_zero),
    .is_odd  (f_odd)
  );

  assign in_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      insn_q  <= '0;
      ctl_q   <= '0;
      dst_q   <= '0;
      src_q   <= '0;
      op_q    <= '0;
      res_q   <= '0;
      z_q     <= 1'b0;
      c_q     <= 1'b0;
      z_out   <= 1'b0;
      c_out   <= 1'b0;
      result  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      done    <= 1'b0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (in_valid) begin
            insn_q <= insn_t'(insn);
            dst_q  <= dst_val;
            src_q  <= src_val;
            z_q    <= z_in;
            c_q    <= c_in;
            st     <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          ctl_q <= ctl_d;
          st    <= ST_OPERAND;
        end
        ST_OPERAND: begin
          op_q <= op_d;
          st   <= ST_COMPUTE;
        end
        ST_COMPUTE: begin
          res_q <= dst_q & ~op_q;
          st    <= ST_FLAGS;
        end
        ST_FLAGS: begin
          done <= 1'b1;
          if (ctl_q.go) begin
            result  <= res_q;
            wr_addr <= ctl_q.dst_a;
            wr_en   <= ctl_q.eff_w;
            z_out   <= ctl_q.eff_z ? f_zero : z_q;
            c_out   <= ctl_q.eff_c ? f_odd : c_q;
          end else begin
            z_out <= z_q;
            c_out <= c_q;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/andn_flag_chk.sv
module andn_flag_chk
  import andn_flag_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [13:0]       hdr,
  input logic              z_in,
  input logic              c_in,
  input logic              z_out,
  input logic              c_out,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic              done
);
  logic [2:0] since_acc;
  logic       l_go;
  logic       l_ez;
  logic       l_ec;
  logic       l_z;
  logic       l_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_acc <= '0;
      l_go      <= 1'b0;
      l_ez      <= 1'b0;
      l_ec      <= 1'b0;
      l_z       <= 1'b0;
      l_c       <= 1'b0;
    end else if (in_valid && in_ready) begin
      since_acc <= 3'd1;
      l_go      <= (hdr[13:8] == OPC_ANDN) && (hdr[3:0] == COND_ALWAYS);
      l_ez      <= hdr[7];
      l_ec      <= hdr[6];
      l_z       <= z_in;
      l_c       <= c_in;
    end else if (since_acc != 3'd0 && since_acc != 3'd7) begin
      since_acc <= since_acc + 3'd1;
    end
  end

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_acc == 3'(LAT + 1)));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  wr_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);

  // R8
  skip_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !l_go) |-> (!wr_en && z_out == l_z && c_out == l_c));

  // R5
  z_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !l_ez) |-> (z_out == l_z));

  // R6
  c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !l_ec) |-> (c_out == l_c));

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(z_out) && $stable(c_out)));
endmodule

bind andn_flag_unit andn_flag_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .hdr      (insn[31:18]),
  .z_in     (z_in),
  .c_in     (c_in),
  .z_out    (z_out),
  .c_out    (c_out),
  .result   (result),
  .wr_en    (wr_en),
  .done     (done)
);

// File: tb/test_andn_flag_unit.sv
`timescale 1ns/1ps
module test_andn_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] insn = '0;
  logic [31:0] dst_val = '0;
  logic [31:0] src_val = '0;
  logic        z_in = 1'b0;
  logic        c_in = 1'b0;
  logic        z_out;
  logic        c_out;
  logic [31:0] result;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] prev_res = '0;
  logic [8:0]  prev_addr = '0;

  always #5 clk = ~clk;

  andn_flag_unit i_andn_flag_unit (
    .clk, .rst_n, .in_valid, .in_ready, .insn, .dst_val, .src_val,
    .z_in, .c_in, .z_out, .c_out, .result, .wr_en, .wr_addr, .done
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit odd_bits(input logic [31:0] v);
    int cnt = 0;
    for (int i = 0; i < 32; i++) cnt += int'(v[i]);
    return (cnt % 2) == 1;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] eff, input logic [3:0] cond,
                                     input logic [8:0] da, input logic [8:0] sf);
    return {6'b011001, eff, cond, da, sf};
  endfunction

  task automatic run_op(input logic [31:0] ins, input logic [31:0] d,
                        input logic [31:0] s, input logic zi, input logic ci,
                        input bit noisy);
    bit          go;
    logic [31:0] opv;
    logic [31:0] er;
    logic        ez;
    logic        ec;
    logic        ew;
    logic [8:0]  ea;
    string       rtag;
    int          lat;
    go   = (ins[31:26] == 6'b011001) && (ins[21:18] == 4'hF);
    opv  = ins[22] ? {23'b0, ins[8:0]} : s;
    er   = go ? (d & ~opv) : prev_res;
    ea   = go ? ins[17:9] : prev_addr;
    ez   = (go && ins[25]) ? ((d & ~opv) == 0) : zi;
    ec   = (go && ins[24]) ? odd_bits(d & ~opv) : ci;
    ew   = go && ins[23];
    rtag = !go ? "R8" : (ins[22] ? "R4" : "R3");

    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready idle", 32'(in_ready), 1);
    in_valid = 1'b1; insn = ins; dst_val = d; src_val = s; z_in = zi; c_in = ci;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 busy", 32'(in_ready), 0);
    if (noisy) begin
      insn = ~ins; dst_val = ~d; src_val = ~s; z_in = ~zi; c_in = ~ci;
    end else begin
      in_valid = 1'b0;
    end
    lat = 0;
    while (lat < 8) begin
      @(negedge clk);
      lat++;
      if (lat == 2) in_valid = 1'b0;
      if (done) break;
    end
    chk(lat == 4, "R2 latency", 32'(lat), 4);
    chk(in_ready == 1'b1, "R2 ready at done", 32'(in_ready), 1);
    chk(result == er, rtag, result, er);
    chk(z_out == ez, go ? "R5" : "R8 z", 32'(z_out), 32'(ez));
    chk(c_out == ec, go ? "R6" : "R8 c", 32'(c_out), 32'(ec));
    chk(wr_en == ew, go ? "R7" : "R8 wr", 32'(wr_en), 32'(ew));
    chk(wr_addr == ea, "R7 addr", 32'(wr_addr), 32'(ea));
    @(negedge clk);
    chk(done == 1'b0 && wr_en == 1'b0, "R2 strobe width", {30'b0, done, wr_en}, 0);
    chk(result == er && z_out == ez && c_out == ec, "R9 hold", result, er);
    prev_res  = er;
    prev_addr = ea;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] dpat [6];
    logic [31:0] spat [6];
    dpat = '{32'hF731_125A, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 32'h1234_5678, 32'hAAAA_5555};
    spat = '{32'hFFFF_FFF8, 32'h0000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFE, 32'h0F0F_F0F0, 32'h5555_AAAA};

    repeat (3) @(negedge clk);
    chk(in_ready == 1 && done == 0 && wr_en == 0 && z_out == 0 && c_out == 0 &&
        result == 0 && wr_addr == 0, "R1 in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1 && done == 0 && wr_en == 0 && z_out == 0 && c_out == 0 &&
        result == 0, "R1 after reset", result, 0);

    // R3, R5, R6: worked examples, flags only
    run_op(mk(4'b1100, 4'hF, 9'd7, 9'd0), 32'hF731_125A, 32'hFFFF_FFFA, 0, 1, 0);
    chk(result == 0 && z_out == 1 && c_out == 0, "R5 example A", result, 0);
    run_op(mk(4'b1100, 4'hF, 9'd7, 9'd0), 32'hF731_125A, 32'hFFFF_FFF8, 1, 0, 0);
    chk(result == 2 && z_out == 0 && c_out == 1, "R6 example B", result, 2);
    run_op(mk(4'b1110, 4'hF, 9'd7, 9'd0), 32'hF731_125A, 32'hFFFF_FFF0, 1, 1, 0);
    chk(result == 32'hA && z_out == 0 && c_out == 0, "R3 example C", result, 32'hA);

    // R3..R7: every effect combination over operand patterns
    for (int e = 0; e < 16; e++)
      for (int p = 0; p < 6; p++)
        run_op(mk(4'(e), 4'hF, 9'(p * 37 + e), 9'(p * 91 + 3)), dpat[p], spat[p],
               1'(p), 1'(~p), 0);

    // R4: literal path swept over every 9-bit value
    for (int l = 0; l < 512; l++)
      run_op(mk(4'b1101, 4'hF, 9'(l), 9'(l)), (l % 2 == 0) ? 32'hFFFF_FFFF : 32'hF731_125A,
             32'h0, 1'(l >> 1), 1'(l >> 2), 0);

    // R8: every non-always condition, then wrong opcodes
    for (int c = 0; c < 15; c++)
      run_op(mk(4'b1111, 4'(c), 9'h1AB, 9'h0F0), 32'hDEAD_BEEF, 32'h0000_FFFF,
             1'(c), 1'(c >> 1), 0);
    run_op({6'b011000, 4'b1111, 4'hF, 9'h055, 9'h0AA}, 32'h1234_0000, 32'h0, 1, 0, 0);
    run_op({6'b111001, 4'b1111, 4'hF, 9'h055, 9'h0AA}, 32'h1234_0000, 32'h0, 0, 1, 0);

    // R2: input activity while busy is ignored
    run_op(mk(4'b1110, 4'hF, 9'h033, 9'h000), 32'hCAFE_F00D, 32'h0F0F_0F0F, 0, 0, 1);
    run_op(mk(4'b1111, 4'hF, 9'h1FF, 9'h1FF), 32'h0000_01FF, 32'h0, 0, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule